// File: doc/BRIEF.md
# Predicated-Result Write Controller

This block sits beside a vector execution unit. For each element it decides whether the computed result is written to the destination, replaced by a zero, or dropped, and whether the element's condition field is stored. It uses three inputs for this: the element's predicate bit, the four-bit condition field the execution unit derived from that element's result, and a set of mode bits shared by all lanes. The block neither computes results nor holds any registers of the register file.

All lanes are evaluated side by side in one pass, since no element depends on another. A vector length input marks which lanes belong to the current vector. The decisions are registered once, so the three enable vectors appear one clock after the request. The per-element test works like a conditional branch test. One condition bit is selected and compared against an invert flag. An element that fails the test behaves as though its destination predicate bit had been clear. Its condition field is still stored, so the vector of condition fields can be examined later.

Top module: `pred_result_wctl`

## Requirements
- R1: While `rst_n` is low, `out_valid_o`, `wr_en_o`, `zero_en_o` and `cr_st_o` are all zero.
- R2: The outputs for a request appear exactly one clock after `in_valid` is sampled high. A cycle in which `in_valid` is low produces `out_valid_o` low and all three enable vectors zero in the next cycle.
- R3: Lane k takes part only when k < `vl_i`. Every lane at or beyond `vl_i` has its write, zero and store enables all low (`vl_i` = 0 gives all-zero vectors).
- R4: A lane whose predicate bit is clear, with `zz_i` = 0, is skipped: no write, no zero, and no condition-field store.
- R5: A lane whose predicate bit is clear, with `zz_i` = 1, gets `zero_en_o` set and still never stores its condition field.
- R6: The condition nibble of lane k is `cond_i[4k+3:4k]` = {lt, gt, eq, so}. `bsel_i` 0, 1, 2 and 3 select lt, gt, eq and so respectively. The test passes when the selected bit differs from `inv_i`. A predicated lane that passes, with `rc1_i` = 0, has `wr_en_o` set.
- R7: A predicated lane that fails the test has its write cancelled. With `zz_i` = 1 it is zeroed instead; with `zz_i` = 0 nothing is written.
- R8: A predicated in-range lane has `cr_st_o` set whenever `rc_i` or `rc1_i` is 1, whether or not its test passes. With both `rc_i` and `rc1_i` at 0, no lane stores.
- R9: With `rc1_i` = 1, `wr_en_o` is never set. With `zz_i` = 1, failing lanes are zeroed and passing lanes get neither write nor zero.
- R10: `wr_en_o` and `zero_en_o` are never both set in the same lane.
- R11: Each lane's outputs depend only on that lane's predicate bit and condition nibble, together with the shared mode bits and `vl_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| vl_i | input | VLW | Vector length (number of lanes in use) |
| pred_i | input | LANES | Predicate bit per lane |
| cond_i | input | 4*LANES | Condition nibble per lane, {lt,gt,eq,so} |
| inv_i | input | 1 | Invert sense of the condition test |
| bsel_i | input | 2 | Condition bit select (0 lt, 1 gt, 2 eq, 3 so) |
| rc_i | input | 1 | Store condition fields |
| rc1_i | input | 1 | Compare-only: store condition fields, discard results |
| zz_i | input | 1 | Zeroing mode for masked-out and failing lanes |
| out_valid_o | output | 1 | Enables below are valid |
| wr_en_o | output | LANES | Write result per lane |
| zero_en_o | output | LANES | Write zero per lane |
| cr_st_o | output | LANES | Store condition field per lane |

## Verification
The four bit selects are each run with both invert settings over nibbles in which the selected bit is set in some lanes and clear in others. This shows that exactly the intended bit drives the test, with the intended polarity. Predicate masks with zeroing off and then on separate skipping from zeroing. Runs with `rc_i` set over lanes that fail the test show that storing the condition field does not depend on the test result. Compare-only runs with zeroing on show that only failing lanes are zeroed. Short, empty and full vector lengths check the lane cut-off. Pseudo-random per-lane mixes of all inputs confirm that lanes do not interact and that write and zero never coincide.

// File: rtl/pred_result_wctl.sv
module pred_result_wctl #(
  parameter int LANES = 8,
  localparam int VLW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [VLW-1:0]     vl_i,
  input  logic [LANES-1:0]   pred_i,
  input  logic [4*LANES-1:0] cond_i,
  input  logic               inv_i,
  input  logic [1:0]         bsel_i,
  input  logic               rc_i,
  input  logic               rc1_i,
  input  logic               zz_i,
  output logic               out_valid_o,
  output logic [LANES-1:0]   wr_en_o,
  output logic [LANES-1:0]   zero_en_o,
  output logic [LANES-1:0]   cr_st_o
);

  logic [LANES-1:0] live, pass, wr_d, zero_d, st_d;
  logic             store_mode;

  assign store_mode = rc_i | rc1_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [VLW:0] IDX = (VLW + 1)'(g);
    logic [3:0] nib;
    assign nib     = cond_i[4*g +: 4];
    assign live[g] = in_valid & ({1'b0, vl_i} > IDX);
    assign pass[g] = nib[2'd3 - bsel_i] ^ inv_i;
  end

  assign wr_d   = live & pred_i & pass & {LANES{~rc1_i}};
  assign zero_d = live & {LANES{zz_i}} & (~pred_i | ~pass);
  assign st_d   = live & pred_i & {LANES{store_mode}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      wr_en_o     <= '0;
      zero_en_o   <= '0;
      cr_st_o     <= '0;
    end else begin
      out_valid_o <= in_valid;
      wr_en_o     <= wr_d;
      zero_en_o   <= zero_d;
      cr_st_o     <= st_d;
    end
  end

endmodule

// File: rtl/pred_result_wctl_chk.sv
module pred_result_wctl_chk #(
  parameter int LANES = 8,
  localparam int VLW = $clog2(LANES + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [VLW-1:0]     vl_i,
  input logic [LANES-1:0]   pred_i,
  input logic               rc_i,
  input logic               rc1_i,
  input logic               zz_i,
  input logic               out_valid_o,
  input logic [LANES-1:0]   wr_en_o,
  input logic [LANES-1:0]   zero_en_o,
  input logic [LANES-1:0]   cr_st_o
);

  logic [LANES-1:0] in_range;
  always_comb begin
    for (int k = 0; k < LANES; k++)
      in_range[k] = ({1'b0, vl_i} > (VLW + 1)'(k));
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid_o && wr_en_o == '0 && zero_en_o == '0 && cr_st_o == '0)); // R2

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid_o); // R2

  AST_BEYOND_VL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((wr_en_o | zero_en_o | cr_st_o) & ~$past(in_range)) == '0)); // R3

  AST_MASKED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((cr_st_o & ~$past(pred_i)) == '0)); // R4

  AST_MASKED_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && zz_i) |=> ((~$past(pred_i) & $past(in_range) & ~zero_en_o) == '0)); // R5

  AST_NO_STORE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rc_i && !rc1_i) |=> (cr_st_o == '0)); // R8

  AST_STORE_ALL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (rc_i || rc1_i)) |=> (cr_st_o == ($past(pred_i) & $past(in_range)))); // R8

  AST_RC1_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rc1_i) |=> (wr_en_o == '0)); // R9

  AST_WR_ZERO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o & zero_en_o) == '0); // R10

  AST_NOZZ_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !zz_i) |=> (zero_en_o == '0)); // R7

endmodule

bind pred_result_wctl pred_result_wctl_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vl_i(vl_i), .pred_i(pred_i),
  .rc_i(rc_i), .rc1_i(rc1_i), .zz_i(zz_i), .out_valid_o(out_valid_o),
  .wr_en_o(wr_en_o), .zero_en_o(zero_en_o), .cr_st_o(cr_st_o)
);

// File: tb/pred_result_wctl_tb_top.sv
module pred_result_wctl_tb_top;
  localparam int LANES = 8;
  localparam int VLW = $clog2(LANES + 1);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [VLW-1:0]     vl_i = '0;
  logic [LANES-1:0]   pred_i = '0;
  logic [4*LANES-1:0] cond_i = '0;
  logic               inv_i = 1'b0;
  logic [1:0]         bsel_i = '0;
  logic               rc_i = 1'b0;
  logic               rc1_i = 1'b0;
  logic               zz_i = 1'b0;
  logic               out_valid_o;
  logic [LANES-1:0]   wr_en_o, zero_en_o, cr_st_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  pred_result_wctl #(.LANES(LANES)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vl_i(vl_i), .pred_i(pred_i),
    .cond_i(cond_i), .inv_i(inv_i), .bsel_i(bsel_i), .rc_i(rc_i), .rc1_i(rc1_i),
    .zz_i(zz_i), .out_valid_o(out_valid_o), .wr_en_o(wr_en_o),
    .zero_en_o(zero_en_o), .cr_st_o(cr_st_o)
  );

  task automatic cmp(input string req, input string what, input logic [LANES-1:0] act,
                     input logic [LANES-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic run(input string req, input int vl, input logic [LANES-1:0] pred,
                     input logic [4*LANES-1:0] cond, input logic inv, input logic [1:0] bsel,
                     input logic rc, input logic rc1, input logic zz);
    logic [LANES-1:0] ew, ez, es;
    for (int l = 0; l < LANES; l++) begin
      logic [3:0] nib = cond[4*l +: 4];
      logic bitv = nib[3 - int'(bsel)];
      logic ok = (bitv != inv);
      logic live = (l < vl);
      ew[l] = live && pred[l] && ok && !rc1;
      ez[l] = live && zz && (!pred[l] || !ok);
      es[l] = live && pred[l] && (rc || rc1);
    end
    @(negedge clk);
    in_valid = 1'b1; vl_i = VLW'(vl); pred_i = pred; cond_i = cond;
    inv_i = inv; bsel_i = bsel; rc_i = rc; rc1_i = rc1; zz_i = zz;
    @(negedge clk);
    in_valid = 1'b0;
    cmp(req, "valid", {{(LANES-1){1'b0}}, out_valid_o}, {{(LANES-1){1'b0}}, 1'b1});
    cmp(req, "wr", wr_en_o, ew);
    cmp(req, "zero", zero_en_o, ez);
    cmp(req, "store", cr_st_o, es);
    cmp("R10", "wr&zero", wr_en_o & zero_en_o, '0);
  endtask

  function automatic logic [4*LANES-1:0] fill(input logic [3:0] nib);
    logic [4*LANES-1:0] c;
    for (int l = 0; l < LANES; l++) c[4*l +: 4] = nib;
    return c;
  endfunction

  task automatic t_reset();
    in_valid = 1'b1; vl_i = VLW'(LANES); pred_i = '1; cond_i = '1; rc_i = 1'b1; zz_i = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1", "valid", {{(LANES-1){1'b0}}, out_valid_o}, '0);
    cmp("R1", "wr", wr_en_o, '0);
    cmp("R1", "zero", zero_en_o, '0);
    cmp("R1", "store", cr_st_o, '0);
    in_valid = 1'b0; rc_i = 1'b0; zz_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_bit_select();
    logic [4*LANES-1:0] c;
    for (int l = 0; l < LANES; l++) c[4*l +: 4] = 4'(l * 5 + 3);
    for (int b = 0; b < 4; b++) begin
      run("R6", LANES, '1, c, 1'b0, 2'(b), 1'b0, 1'b0, 1'b0);
      run("R7", LANES, '1, c, 1'b1, 2'(b), 1'b0, 1'b0, 1'b0);
    end
    run("R6", LANES, '1, fill(4'b0010), 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
    cmp("R6", "eq set all write", wr_en_o, '1);
    run("R7", LANES, '1, fill(4'b0010), 1'b1, 2'd2, 1'b0, 1'b0, 1'b1);
    cmp("R7", "eq set inv zeroed", zero_en_o, '1);
  endtask

  task automatic t_masked();
    run("R4", LANES, 8'b1010_0110, fill(4'b1000), 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    cmp("R4", "masked skipped", (wr_en_o | zero_en_o | cr_st_o) & ~8'b1010_0110, '0);
    run("R5", LANES, 8'b1010_0110, fill(4'b1000), 1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
    cmp("R5", "masked zeroed", zero_en_o, ~8'b1010_0110);
  endtask

  task automatic t_store();
    run("R8", LANES, '1, fill(4'b0000), 1'b0, 2'd1, 1'b1, 1'b0, 1'b0);
    cmp("R8", "store on fail", cr_st_o, '1);
    run("R8", LANES, '1, fill(4'b0100), 1'b0, 2'd1, 1'b0, 1'b0, 1'b0);
    cmp("R8", "no store mode", cr_st_o, '0);
  endtask

  task automatic t_rc1();
    logic [4*LANES-1:0] c = '0;
    for (int l = 0; l < LANES; l += 2) c[4*l +: 4] = 4'b0001;
    run("R9", LANES, '1, c, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1);
    cmp("R9", "fail zeroed", zero_en_o, 8'b1010_1010);
    cmp("R9", "never write", wr_en_o, '0);
    run("R9", LANES, 8'b0000_1111, c, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_vl();
    run("R3", 0, '1, fill(4'b1111), 1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
    cmp("R3", "vl0 empty", wr_en_o | zero_en_o | cr_st_o, '0);
    run("R3", 3, 8'b1111_1011, fill(4'b0100), 1'b0, 2'd1, 1'b1, 1'b0, 1'b1);
    cmp("R3", "vl3 cut", (wr_en_o | zero_en_o | cr_st_o) & 8'b1111_1000, '0);
    run("R3", LANES, 8'b0111_1111, fill(4'b0100), 1'b0, 2'd1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_idle();
    run("R2", LANES, '1, fill(4'b1111), 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    cmp("R2", "idle valid", {{(LANES-1){1'b0}}, out_valid_o}, '0);
    cmp("R2", "idle enables", wr_en_o | zero_en_o | cr_st_o, '0);
  endtask

  task automatic t_lanes();
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng); b = rng;
      run("R11", int'(a[27:24]) % (LANES + 1), a[7:0], b, a[8], a[10:9], a[11], a[12], a[13]);
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    t_reset();
    t_bit_select();
    t_masked();
    t_store();
    t_rc1();
    t_vl();
    t_idle();
    t_lanes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule